// File: doc/BRIEF.md
# Sequential Signed Divider

The block divides a signed two's-complement dividend of twice the data width by a signed divisor of the data width. It works on magnitudes, one quotient bit per clock. A request is raised with a one-cycle `start` strobe while the block is idle. The block registers the operands and strips their signs, then screens the request before iterating. A zero divisor and a quotient that cannot fit end the request early with a flag. So does a dividend that is already smaller than the divisor.

A request that passes the screen runs W restoring steps. Each step shifts the partial remainder and quotient left together, then tries to subtract the divisor. After the last step the quotient magnitude is rounded to nearest, and the sign is applied. Results and flags stay on the outputs until the next request completes. `done` pulses for one cycle to mark each completion.

Top module: `seq_sdiv`

## Requirements
- R1: A `start` seen while `busy` is 0 is accepted, and `busy` is 1 on the following cycle. A `start` seen while `busy` is 1 is ignored and does not change the result of the request in flight.
- R2: `done` is a one-cycle pulse, and `busy` is 0 in that cycle. Counting clock edges after the accepting edge, `done` rises after 1 edge for a request that ends early (R3, R4, R5) and after W+2 edges otherwise.
- R3: If the divisor is non-zero and the upper W bits of |dividend| are at least |divisor|, the result is `ovf`=1, `dz`=0, `quotient`=0 and `remainder`=0.
- R4: If the divisor is zero, the result is `dz`=1, `ovf`=0, `quotient`=0 and `remainder`=0. This check wins over R3.
- R5: If the upper W bits of |dividend| are zero and the lower W bits are below a non-zero |divisor|, the result is `quotient`=0 and `remainder`=|dividend|, with no rounding applied.
- R6: In every other case, the quotient magnitude is floor(|dividend|/|divisor|). `remainder` is the unsigned value |dividend| mod |divisor|.
- R7: The quotient magnitude is incremented when 2×remainder ≥ |divisor|. The sum is taken modulo 2^W.
- R8: The quotient is negated in two's complement, modulo 2^W, when the sign bits (MSBs) of the dividend and the divisor differ. `remainder` is always a magnitude.
- R9: After reset, every output is 0. `quotient`, `remainder`, `ovf` and `dz` change only in the cycle where `done` is 1, and hold their values until the next completion.
- R10: A completion through R5 or R6 clears both `ovf` and `dz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| dividend | input | 2*W | Signed dividend |
| divisor | input | W | Signed divisor |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Signed quotient, rounded |
| remainder | output | W | Remainder magnitude |
| ovf | output | 1 | Quotient would not fit in W bits |
| dz | output | 1 | Divisor was zero |

## Verification
The bench targets the edges of the overflow screen. One case has an upper half exactly equal to the divisor, which must flag. Another has an upper half one below it, which must iterate. A design that used a strict comparison would return a wrapped quotient instead of flagging. A zero divisor must report `dz` alone, not `ovf`, and the most negative operands must take their magnitudes correctly.

A small dividend whose remainder would round up checks that the early exit skips rounding. A maximal magnitude that rounds to 2^W checks the wrap. Exact-half remainders check the tie direction. A `start` raised mid-request checks that a block which reloads its operands would corrupt the result.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCREEN = 2'd1,
        ST_STEP = 2'd2,
        ST_WRAP = 2'd3
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_unsign.sv
module sdiv_unsign #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] dvd,
    input  logic [W-1:0]   dvs,
    output logic [W-1:0]   mag_hi,
    output logic [W-1:0]   mag_lo,
    output logic [W-1:0]   mag_dvs,
    output logic           neg_quo
);
    logic [2*W-1:0] mag_dvd;

    always_comb begin
        mag_dvd = dvd[2*W-1] ? (~dvd + 1'b1) : dvd;
        mag_dvs = dvs[W-1] ? (~dvs + 1'b1) : dvs;
        mag_hi  = mag_dvd[2*W-1:W];
        mag_lo  = mag_dvd[W-1:0];
        neg_quo = dvd[2*W-1] ^ dvs[W-1];
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] part_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] part_out,
    output logic [W-1:0] quo_out
);
    logic [W:0]   shifted;
    logic [W-1:0] trial;
    logic         fits;

    always_comb begin
        shifted  = {part_in, quo_in[W-1]};
        fits     = shifted >= {1'b0, dvs};
        trial    = shifted[W-1:0] - dvs;
        part_out = fits ? trial : shifted[W-1:0];
        quo_out  = {quo_in[W-2:0], fits};
    end
endmodule

// File: rtl/sdiv_finish.sv
module sdiv_finish #(
    parameter int W = 8
) (
    input  logic [W-1:0] part,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] dvs,
    input  logic         neg,
    output logic [W-1:0] quo_out
);
    logic         bump;
    logic [W-1:0] rounded;

    always_comb begin
        bump    = {part, 1'b0} >= {1'b0, dvs};
        rounded = quo_mag + {{(W-1){1'b0}}, bump};
        quo_out = neg ? (~rounded + 1'b1) : rounded;
    end
endmodule

// File: rtl/seq_sdiv.sv
module seq_sdiv
    import sdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           ovf,
    output logic           dz
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        sdiv_state_e   st;
        logic [W-1:0]  part;
        logic [W-1:0]  qreg;
        logic [W-1:0]  dvs;
        logic          neg;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
        logic          ovf;
        logic          dz;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
    } sdiv_regs_t;

    sdiv_regs_t r_q, r_d;

    logic [W-1:0] in_hi, in_lo, in_dvs;
    logic         in_neg;
    logic [W-1:0] step_part, step_quo;
    logic [W-1:0] fin_quo;

    sdiv_unsign #(.W(W)) u_unsign (
        .dvd(dividend), .dvs(divisor),
        .mag_hi(in_hi), .mag_lo(in_lo), .mag_dvs(in_dvs), .neg_quo(in_neg)
    );

    sdiv_step #(.W(W)) u_step (
        .part_in(r_q.part), .quo_in(r_q.qreg), .dvs(r_q.dvs),
        .part_out(step_part), .quo_out(step_quo)
    );

    sdiv_finish #(.W(W)) u_finish (
        .part(r_q.part), .quo_mag(r_q.qreg), .dvs(r_q.dvs), .neg(r_q.neg),
        .quo_out(fin_quo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.part = in_hi;
                    r_d.qreg = in_lo;
                    r_d.dvs  = in_dvs;
                    r_d.neg  = in_neg;
                    r_d.busy = 1'b1;
                    r_d.st   = ST_SCREEN;
                end
            end
            ST_SCREEN: begin
                if (r_q.dvs == '0) begin
                    r_d.dz  = 1'b1;
                    r_d.ovf = 1'b0;
                    r_d.quo = '0;
                    r_d.rem = '0;
                end else if (r_q.part >= r_q.dvs) begin
                    r_d.dz  = 1'b0;
                    r_d.ovf = 1'b1;
                    r_d.quo = '0;
                    r_d.rem = '0;
                end else if (r_q.part == '0 && r_q.qreg < r_q.dvs) begin
                    r_d.dz  = 1'b0;
                    r_d.ovf = 1'b0;
                    r_d.quo = '0;
                    r_d.rem = r_q.qreg;
                end
                if (r_q.dvs == '0 || r_q.part >= r_q.dvs ||
                    (r_q.part == '0 && r_q.qreg < r_q.dvs)) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = '0;
                    r_d.st  = ST_STEP;
                end
            end
            ST_STEP: begin
                r_d.part = step_part;
                r_d.qreg = step_quo;
                r_d.cnt  = r_q.cnt + CW'(1);
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_WRAP;
                end
            end
            ST_WRAP: begin
                r_d.quo  = fin_quo;
                r_d.rem  = r_q.part;
                r_d.ovf  = 1'b0;
                r_d.dz   = 1'b0;
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign quotient  = r_q.quo;
    assign remainder = r_q.rem;
    assign ovf       = r_q.ovf;
    assign dz        = r_q.dz;
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [2*W-1:0] dividend,
    input logic [W-1:0]   divisor,
    input logic           busy,
    input logic           done,
    input logic [W-1:0]   quotient,
    input logic [W-1:0]   remainder,
    input logic           ovf,
    input logic           dz
);
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (quotient == '0 && remainder == '0 && !dz));

    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dz |-> (quotient == '0 && remainder == '0 && !ovf));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(ovf) && $stable(dz)));

    p_no_done_while_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !done);
endmodule

bind seq_sdiv sdiv_chk #(.W(W)) u_sdiv_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .ovf(ovf), .dz(dz)
);

// File: tb/seq_sdiv_test.sv
module seq_sdiv_test;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam longint MOD = longint'(1) << W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2*W-1:0] dividend = '0;
    logic [W-1:0]   divisor = '0;
    logic           busy, done, ovf, dz;
    logic [W-1:0]   quotient, remainder;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    seq_sdiv #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .ovf(ovf), .dz(dz)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: expected result and completion latency
    task automatic model(input logic [2*W-1:0] d, input logic [W-1:0] v,
                         output longint eq, output longint er, output longint eo,
                         output longint ez, output int lat);
        longint sd, sv, md, mv, hi, lo, q, r;
        sd = d[2*W-1] ? longint'(d) - (longint'(1) << (2*W)) : longint'(d);
        sv = v[W-1] ? longint'(v) - MOD : longint'(v);
        md = (sd < 0) ? -sd : sd;
        mv = (sv < 0) ? -sv : sv;
        hi = md >> W;
        lo = md % MOD;
        eq = 0; er = 0; eo = 0; ez = 0; lat = 1;
        if (mv == 0) begin
            ez = 1;
        end else if (hi >= mv) begin
            eo = 1;
        end else if (hi == 0 && lo < mv) begin
            er = lo;
        end else begin
            lat = W + 2;
            q = md / mv;
            r = md % mv;
            if (2 * r >= mv) q = q + 1;
            q = q % MOD;
            if ((sd < 0) != (sv < 0)) q = (MOD - q) % MOD;
            eq = q;
            er = r;
        end
    endtask

    task automatic run_div(input string req, input logic [2*W-1:0] d,
                           input logic [W-1:0] v, input bit poke);
        longint eq, er, eo, ez;
        int lat;
        longint pq, pr, po, pz;
        model(d, v, eq, er, eo, ez, lat);
        pq = quotient; pr = remainder; po = ovf; pz = dz;
        @(negedge clk);
        dividend = d; divisor = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= lat; k++) begin
            if (k > 0) @(negedge clk);
            start = 1'b0;
            dividend = d; divisor = v;
            chk({req, " R2 done timing"}, done, (k == lat) ? 1 : 0);
            chk({req, " R1 busy"}, busy, (k < lat) ? 1 : 0);
            if (k < lat) begin
                chk({req, " R9 quotient held"}, quotient, pq);
                chk({req, " R9 remainder held"}, remainder, pr);
                chk({req, " R9 flags held"}, {ovf, dz}, {po[0], pz[0]});
            end
            if (poke && k == 1 && lat > 2) begin
                dividend = ~d; divisor = v + 8'd3; start = 1'b1;
            end
        end
        chk({req, " R3/R6/R7/R8 quotient"}, quotient, eq);
        chk({req, " R5/R6 remainder"}, remainder, er);
        chk({req, " R3/R10 ovf"}, ovf, eo);
        chk({req, " R4/R10 dz"}, dz, ez);
        @(negedge clk);
        chk({req, " R2 done single cycle"}, done, 0);
        chk({req, " R9 quotient kept"}, quotient, eq);
        chk({req, " R9 remainder kept"}, remainder, er);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] seed;
        seed = 16'hACE1;
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset done", done, 0);
        chk("R9 reset quotient", quotient, 0);
        chk("R9 reset remainder", remainder, 0);
        chk("R9 reset flags", {ovf, dz}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div("R6 100/7", 16'd100, 8'd7, 1'b0);
        run_div("R7 100/8 rounds up", 16'd100, 8'd8, 1'b0);
        run_div("R7 tie 9/6", 16'd9, 8'd6, 1'b0);
        run_div("R8 -100/7", 16'hFF9C, 8'd7, 1'b0);
        run_div("R8 100/-7", 16'd100, 8'hF9, 1'b0);
        run_div("R8 -100/-7", 16'hFF9C, 8'hF9, 1'b0);
        run_div("R4 zero divisor", 16'd1234, 8'd0, 1'b0);
        run_div("R6 recovers flags R10", 16'd300, 8'd9, 1'b0);
        run_div("R3 hi equals divisor", 16'h0500, 8'd5, 1'b0);
        run_div("R3 negative hi equals divisor", 16'hFB00, 8'hFB, 1'b0);
        run_div("R7 wrap 1279/5", 16'h04FF, 8'd5, 1'b0);
        run_div("R8 wrap 1279/-5", 16'h04FF, 8'hFB, 1'b0);
        run_div("R3 min/min", 16'h8000, 8'h80, 1'b0);
        run_div("R7 32766/-128", 16'h7FFE, 8'h80, 1'b0);
        run_div("R5 trivial 5/7 no rounding", 16'd5, 8'd7, 1'b0);
        run_div("R5 trivial -3/7", 16'hFFFD, 8'd7, 1'b0);
        run_div("R4 zero over zero", 16'd0, 8'd0, 1'b0);
        run_div("R1 start ignored while busy", 16'd1000, 8'd13, 1'b1);
        run_div("R1 start ignored negative", 16'hF000, 8'd77, 1'b1);

        for (int i = 0; i < 60; i++) begin
            logic [2*W-1:0] d;
            logic [W-1:0] v;
            seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
            d = seed;
            seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
            v = seed[W-1:0] | 8'h40;
            if (i % 3 == 0) d = {{W{d[W-1]}}, d[W-1:0]};
            run_div("R6 sweep", d, v, (i % 5) == 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule